// File: doc/BRIEF.md
# Isochronous Interval Interrupt Generator

This block produces a steady periodic interrupt from a free-running nanosecond time base. Software loads an interval length and a start time, both in nanoseconds. The block compares the start time with the current time on every clock. When the time reaches or passes that start, the block sets a sticky status bit. It then moves the start time forward by exactly one interval, so the next event is scheduled from the programmed grid and not from the moment the event was seen. Errors therefore never accumulate.

The time input is a 29-bit word that counts in 16 ns units. The block scales it to nanoseconds by shifting it left by four bits and keeps the low 32 bits. Because the time advances in 16 ns steps, an exact match may never occur. The compare therefore treats the signed 32-bit difference (time minus start) as "reached" whenever it is zero or positive. This test also works when either value wraps past 2^32.

Software controls the block through a single write port with a 2-bit register select. The interrupt output is a level signal. It is high while the status bit is set and the mask bit is clear.

Top module: `iso_tick_gen`

## Requirements
- R1: After reset, the status bit is 0, the interrupt output is 0, the next-start value is 0, the interval is 0, the comparator is disarmed and the mask bit is 1 (masked).
- R2: A write with `wr_sel_i` = 0 loads `wr_data_i` into the next-start register and arms the comparator; this load wins over an advance in the same cycle. A write with `wr_sel_i` = 1 loads the interval.
- R3: The current time in nanoseconds is `time_i` shifted left by 4, taken modulo 2^32. An event occurs in a cycle in which the comparator is armed and (time minus next-start) is zero or positive as a signed 32-bit value. An event also occurs when the time has passed the start without ever equalling it.
- R4: On an event with a nonzero interval, the status bit is set one clock later and next-start grows by the interval.
- R5: On an event with a zero interval, the status bit is set, next-start is left unchanged and the comparator disarms. No further event occurs until next-start is written again.
- R6: A write with `wr_sel_i` = 2 and data bit 0 = 1 clears the status bit. Data bit 0 = 0 has no effect. If an event happens in the same cycle, the status bit stays set.
- R7: A write with `wr_sel_i` = 3 loads the mask from data bit 0. `irq_o` is high exactly when the status bit is 1 and the mask is 0. The mask never changes the status bit.
- R8: While the comparator is disarmed, the status bit is never set, whatever the time value is.
- R9: The next-start advance wraps modulo 2^32, and the signed compare still finds the event across that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_i | input | 29 | Time base word, in 16 ns units |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 start, 1 interval, 2 status clear, 3 mask |
| wr_data_i | input | 32 | Write data |
| irq_o | output | 1 | Level interrupt: status and not mask |
| status_o | output | 1 | Sticky event status bit |
| next_start_o | output | 32 | Current next-start value in nanoseconds |

## Verification
The time input is applied in several patterns:
- A value just below the start checks that the compare does not fire early.
- A value exactly equal to the start checks the inclusive boundary.
- A value that jumps past the start checks that the block cannot skip an event because of the 16 ns granularity.
- A start just below 2^32, reached by the largest time word, checks that the sum wraps and that the signed compare still works after the wrap.
- A zero interval, followed by a later time and then a rewrite of the start, separates one-shot disarming from periodic reloading.
- A clear that coincides with an event, a clear written with bit 0 at zero, and mask toggles while the status bit is set separate the clear-versus-set priority from the masking of the output.

// File: rtl/iso_tick_pkg.sv
package iso_tick_pkg;

    localparam int NS_W  = 32;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_START = 2'd0,
        SEL_LEN   = 2'd1,
        SEL_CLR   = 2'd2,
        SEL_MASK  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NS_W-1:0] next_start;
        logic [NS_W-1:0] interval;
        logic            armed;
        logic            status;
        logic            mask;
    } tick_state_t;

endpackage

// File: rtl/iso_tick_cmp.sv
module iso_tick_cmp
    import iso_tick_pkg::*;
#(
    parameter int TIME_W     = 29,
    parameter int GRAN_SHIFT = 4
) (
    input  logic [TIME_W-1:0] time_i,
    input  logic [NS_W-1:0]   target_i,
    input  logic              armed_i,
    output logic              hit_o
);
    logic [NS_W-1:0] wide_time;
    logic [NS_W-1:0] now_ns;
    logic [NS_W-1:0] diff;

    generate
        if (TIME_W >= NS_W) begin : g_trunc
            assign wide_time = time_i[NS_W-1:0];
        end else begin : g_ext
            assign wide_time = {{(NS_W-TIME_W){1'b0}}, time_i};
        end
    endgenerate

    // Scale the 16 ns ticks to ns; bits above NS_W fall off (mod 2^NS_W).
    assign now_ns = wide_time << GRAN_SHIFT;
    assign diff   = now_ns - target_i;
    // Reached or passed: signed difference not negative.
    assign hit_o  = armed_i & ~diff[NS_W-1];

endmodule

// File: rtl/iso_tick_adv.sv
module iso_tick_adv
    import iso_tick_pkg::*;
(
    input  logic [NS_W-1:0] start_i,
    input  logic [NS_W-1:0] interval_i,
    output logic [NS_W-1:0] sum_o,
    output logic            periodic_o
);
    assign sum_o      = start_i + interval_i;
    assign periodic_o = |interval_i;
endmodule

// File: rtl/iso_tick_gen.sv
module iso_tick_gen
    import iso_tick_pkg::*;
#(
    parameter int TIME_W     = 29,
    parameter int GRAN_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [NS_W-1:0]   wr_data_i,
    output logic              irq_o,
    output logic              status_o,
    output logic [NS_W-1:0]   next_start_o
);
    tick_state_t     st_q, st_d;
    logic            hit;
    logic [NS_W-1:0] adv_sum;
    logic            adv_periodic;
    reg_sel_e        sel;

    assign sel = reg_sel_e'(wr_sel_i);

    iso_tick_cmp #(
        .TIME_W     (TIME_W),
        .GRAN_SHIFT (GRAN_SHIFT)
    ) cmp_i (
        .time_i   (time_i),
        .target_i (st_q.next_start),
        .armed_i  (st_q.armed),
        .hit_o    (hit)
    );

    iso_tick_adv adv_i (
        .start_i    (st_q.next_start),
        .interval_i (st_q.interval),
        .sum_o      (adv_sum),
        .periodic_o (adv_periodic)
    );

    always_comb begin
        st_d = st_q;
        if (hit) begin
            st_d.status = 1'b1;
            if (adv_periodic) begin
                st_d.next_start = adv_sum;
            end else begin
                st_d.armed = 1'b0;
            end
        end
        if (wr_en_i) begin
            unique case (sel)
                SEL_START: begin
                    st_d.next_start = wr_data_i;
                    st_d.armed      = 1'b1;
                end
                SEL_LEN:  st_d.interval = wr_data_i;
                SEL_CLR: begin
                    if (wr_data_i[0] && !hit) begin
                        st_d.status = 1'b0;
                    end
                end
                SEL_MASK: st_d.mask = wr_data_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{next_start: '0, interval: '0, armed: 1'b0,
                      status: 1'b0, mask: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o        = st_q.status & ~st_q.mask;
    assign status_o     = st_q.status;
    assign next_start_o = st_q.next_start;

    logic wr_start;
    assign wr_start = wr_en_i && (sel == SEL_START);

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> next_start_o == $past(wr_data_i));

    p_status_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o) |-> $past(hit));

    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && st_q.interval != '0 && !wr_start)
        |=> next_start_o == $past(st_q.next_start) + $past(st_q.interval));

    p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && st_q.interval == '0 && !wr_start) |=> !st_q.armed);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel == SEL_CLR && wr_data_i[0] && !hit) |=> !status_o);

    p_disarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !wr_start && !status_o) |=> !status_o);

endmodule

// File: tb/iso_tick_gen_tb_top.sv
module iso_tick_gen_tb_top;
    import iso_tick_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [28:0] time_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        irq_o, status_o;
    logic [31:0] next_start_o;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    iso_tick_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .time_i       (time_i),
        .wr_en_i      (wr_en_i),
        .wr_sel_i     (wr_sel_i),
        .wr_data_i    (wr_data_i),
        .irq_o        (irq_o),
        .status_o     (status_o),
        .next_start_o (next_start_o)
    );

    typedef struct packed {
        logic [28:0] t;
        logic        we;
        logic [1:0]  sel;
        logic [31:0] d;
        logic        st;
        logic        irq;
        logic [31:0] nx;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{29'd0,  1'b1, 2'd3, 32'd0,   1'b0, 1'b0, 32'd0},   // R8 unarmed, R7 unmask
        '{29'd0,  1'b1, 2'd1, 32'd100, 1'b0, 1'b0, 32'd0},   // R2 interval
        '{29'd0,  1'b1, 2'd0, 32'd160, 1'b0, 1'b0, 32'd160}, // R2 start
        '{29'd9,  1'b0, 2'd0, 32'd0,   1'b0, 1'b0, 32'd160}, // R3 below
        '{29'd10, 1'b0, 2'd0, 32'd0,   1'b1, 1'b1, 32'd260}, // R3 equal, R4
        '{29'd10, 1'b1, 2'd2, 32'd1,   1'b0, 1'b0, 32'd260}, // R6 clear
        '{29'd16, 1'b0, 2'd0, 32'd0,   1'b0, 1'b0, 32'd260}, // R3 below
        '{29'd17, 1'b0, 2'd0, 32'd0,   1'b1, 1'b1, 32'd360}, // R3 passed, R4
        '{29'd17, 1'b1, 2'd3, 32'd1,   1'b1, 1'b0, 32'd360}, // R7 mask
        '{29'd23, 1'b1, 2'd2, 32'd1,   1'b1, 1'b0, 32'd460}, // R6 event wins
        '{29'd23, 1'b1, 2'd3, 32'd0,   1'b1, 1'b1, 32'd460}, // R7 unmask
        '{29'd23, 1'b1, 2'd2, 32'd0,   1'b1, 1'b1, 32'd460}, // R6 bit0 zero
        '{29'd23, 1'b1, 2'd2, 32'd1,   1'b0, 1'b0, 32'd460}, // R6 clear
        '{29'd23, 1'b1, 2'd0, 32'hFFFF_FFF0, 1'b0, 1'b0, 32'hFFFF_FFF0}, // R2
        '{29'h1FFF_FFFF, 1'b0, 2'd0, 32'd0, 1'b1, 1'b1, 32'h54}, // R9 wrap
        '{29'd0,  1'b1, 2'd2, 32'd1,   1'b0, 1'b0, 32'h54},  // R9 after wrap
        '{29'd6,  1'b0, 2'd0, 32'd0,   1'b1, 1'b1, 32'd184}, // R9 hit
        '{29'd6,  1'b1, 2'd2, 32'd1,   1'b0, 1'b0, 32'd184},
        '{29'd6,  1'b1, 2'd1, 32'd0,   1'b0, 1'b0, 32'd184}, // R5 zero len
        '{29'd12, 1'b0, 2'd0, 32'd0,   1'b1, 1'b1, 32'd184}, // R5 one-shot
        '{29'd12, 1'b1, 2'd2, 32'd1,   1'b0, 1'b0, 32'd184}, // R5 no refire
        '{29'd12, 1'b0, 2'd0, 32'd0,   1'b0, 1'b0, 32'd184}, // R5 R8
        '{29'd12, 1'b1, 2'd0, 32'd200, 1'b0, 1'b0, 32'd200}, // R2 re-arm
        '{29'd13, 1'b0, 2'd0, 32'd0,   1'b1, 1'b1, 32'd200}, // R5 rearmed
        '{29'd13, 1'b1, 2'd2, 32'd1,   1'b0, 1'b0, 32'd200}  // R5 disarmed
    };

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [28:0] t, input logic we,
                        input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        time_i = t; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 status", {31'd0, status_o}, 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 next", next_start_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].t, VECS[i].we, VECS[i].sel, VECS[i].d);
            chk($sformatf("vec%0d status", i), {31'd0, status_o}, {31'd0, VECS[i].st});
            chk($sformatf("vec%0d irq R7", i), {31'd0, irq_o}, {31'd0, VECS[i].irq});
            chk($sformatf("vec%0d next", i), next_start_o, VECS[i].nx);
        end
        // Directed: mid-run reset restores defaults (R1), mask defaults to 1.
        @(negedge clk);
        rst_n = 1'b0; wr_en_i = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset status", {31'd0, status_o}, 32'd0);
        chk("R1 reset next", next_start_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(29'd0, 1'b1, 2'd0, 32'd0);   // arm at 0, interval 0 after reset
        step(29'd0, 1'b0, 2'd0, 32'd0);   // event fires, masked by default
        chk("R1 default mask status", {31'd0, status_o}, 32'd1);
        chk("R1 default mask irq", {31'd0, irq_o}, 32'd0);
        chk("R1 interval zero keeps next", next_start_o, 32'd0);
        step(29'd0, 1'b1, 2'd3, 32'd0);
        chk("R7 unmask irq", {31'd0, irq_o}, 32'd1);
        // Directed: large interval, several periodic events (R4).
        step(29'd0, 1'b1, 2'd1, 32'd4096);
        step(29'd0, 1'b1, 2'd0, 32'd1000);
        step(29'd0, 1'b1, 2'd2, 32'd1);
        step(29'd63, 1'b0, 2'd0, 32'd0);  // 1008 passed 1000
        chk("R4 first advance", next_start_o, 32'd5096);
        step(29'd63, 1'b1, 2'd2, 32'd1);
        step(29'd400, 1'b0, 2'd0, 32'd0); // 6400 passed 5096
        chk("R4 second advance", next_start_o, 32'd9192);
        chk("R4 status", {31'd0, status_o}, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule